// File: doc/BRIEF.md
# Iterative Byte/Word Multiply-Divide Unit

This block performs signed and unsigned integer multiplication and division on 8-bit (byte) or 16-bit (word) operands, using a fixed accumulator-pair convention. The caller presents an operation code, a size select, a source operand and the current contents of the accumulator (`axIn`) and extension register (`dxIn`), then pulses `startIn`. The unit captures everything on that edge, runs a shift-add multiply or a restoring divide on operand magnitudes for one cycle per operand bit, applies the result signs in one more cycle, and then pulses `doneOut` with the new accumulator and extension values.

For byte operations the "low half" of a 16-bit register means bits 7:0 and the "high half" means bits 15:8. Multiply results report through a paired overflow/carry flag whether the upper half of the product carries information. A division whose divisor is zero, or whose quotient cannot fit the destination, raises `divErrOut` and returns the accumulator and extension values untouched.

Top module: `muldiv_iter`

## Requirements
- R1: With `opIn`=0 (unsigned multiply) or 1 (signed multiply) and `wideIn`=0, `axOut` receives the 16-bit product of `axIn[7:0]` and `srcIn[7:0]`; `axIn[15:8]` has no effect and `dxOut` equals the captured `dxIn`.
- R2: With a multiply code and `wideIn`=1, the 32-bit product of `axIn` and `srcIn` is returned with bits 31:16 on `dxOut` and bits 15:0 on `axOut`.
- R3: After any multiply `ovfOut` and `carryOut` are equal; they are 1 exactly when the upper half of the product is needed (unsigned: upper half nonzero; signed: upper half differs from the sign extension of the lower half).
- R4: With `opIn`=2 (unsigned divide) and `wideIn`=0, the 16-bit `axIn` is divided by `srcIn[7:0]`; the quotient goes to `axOut[7:0]`, the remainder to `axOut[15:8]`, and `dxOut` equals the captured `dxIn`.
- R5: With a divide code and `wideIn`=1, the 32-bit dividend `{dxIn,axIn}` is divided by `srcIn`; the quotient goes to `axOut` and the remainder to `dxOut`.
- R6: With `opIn`=3 (signed divide) operands are two's complement, the quotient truncates toward zero and a nonzero remainder carries the sign of the dividend.
- R7: A zero divisor, or a quotient outside the destination range (unsigned 0..2^n-1, signed -2^(n-1)..2^(n-1)-1 for n-bit size), sets `divErrOut`=1 and returns the captured `axIn` and `dxIn`; successful divides and all multiplies return `divErrOut`=0.
- R8: After any divide `ovfOut` and `carryOut` are both 0.
- R9: `doneOut` is a one-cycle pulse that rises 9 clock edges after the start edge for byte operations and 17 for word operations; operands are captured on the start edge, so later input changes have no effect.
- R10: A `startIn` pulse while an operation is in progress is ignored: the running result is unchanged and no extra `doneOut` appears.
- R11: Asynchronous active-low reset clears all outputs to 0 and abandons any operation in progress without a `doneOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start request, taken only when idle |
| opIn | input | 2 | 0 unsigned mul, 1 signed mul, 2 unsigned div, 3 signed div |
| wideIn | input | 1 | 0 byte operands, 1 word operands |
| srcIn | input | 16 | Source operand (multiplier or divisor) |
| axIn | input | 16 | Accumulator value |
| dxIn | input | 16 | Extension register value |
| axOut | output | 16 | Updated accumulator |
| dxOut | output | 16 | Updated extension register |
| ovfOut | output | 1 | Overflow flag |
| carryOut | output | 1 | Carry flag |
| doneOut | output | 1 | Result valid, one-cycle pulse |
| divErrOut | output | 1 | Divide error for the completed operation |

## Verification
The bound checker watches every cycle for the flag pairing, the cleared flags after a divide, the untouched accumulator pair on a divide error, the preserved extension register on byte operations, the product-width rule read back from the outputs, and the exact latency and single-cycle width of the completion pulse including its absence while busy. Arithmetic correctness across signs, sizes and the edge quotients such as the most negative value only shows through the bench's vector table, whose expected values come from an independent integer model. Reset during an operation and a second start while busy are covered by directed bench scenarios.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MULU = 2'd0,
    OP_MULS = 2'd1,
    OP_DIVU = 2'd2,
    OP_DIVS = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands and magnitudes
    logic step;    // one shift-add / restoring iteration
    logic finish;  // sign fix-up and result write
  } strobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
`timescale 1ns/1ps
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  input  logic    wideIn,
  output strobe_t strb,
  output logic    doneOut
);

  localparam int HALF = DATA_W / 2;
  localparam int CW   = $clog2(DATA_W);

  ctrl_state_e state;
  logic [CW-1:0] iterCnt;

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE: strb.load   = startIn;
      ST_RUN:  strb.step   = 1'b1;
      ST_FIX:  strb.finish = 1'b1;
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= strb.finish;
      case (state)
        ST_IDLE: begin
          if (startIn) begin
            state   <= ST_RUN;
            iterCnt <= wideIn ? CW'(DATA_W - 1) : CW'(HALF - 1);
          end
        end
        ST_RUN: begin
          if (iterCnt == '0) begin
            state <= ST_FIX;
          end else begin
            iterCnt <= iterCnt - 1'b1;
          end
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/muldiv_dpath.sv
`timescale 1ns/1ps
module muldiv_dpath
  import muldiv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        opIn,
  input  logic              wideIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] axIn,
  input  logic [DATA_W-1:0] dxIn,
  output logic [DATA_W-1:0] axOut,
  output logic [DATA_W-1:0] dxOut,
  output logic              ovfOut,
  output logic              carryOut,
  output logic              divErrOut
);

  localparam int W    = DATA_W;
  localparam int HALF = W / 2;
  localparam int W2   = 2 * W;

  // ---------------- operand conditioning (load cycle) ----------------
  logic          isDivIn, isSignedIn;
  logic [W-1:0]  srcSel, srcMag, mulSel, mulMag, divHi, divLo;
  logic          srcNeg, mulNeg, dvdNeg;
  logic [W2-1:0] dividend, dvdMag;

  always_comb begin
    isDivIn    = (opIn == OP_DIVU) || (opIn == OP_DIVS);
    isSignedIn = (opIn == OP_MULS) || (opIn == OP_DIVS);

    srcSel = wideIn ? srcIn
                    : {{HALF{isSignedIn & srcIn[HALF-1]}}, srcIn[HALF-1:0]};
    srcNeg = isSignedIn & srcSel[W-1];
    srcMag = srcNeg ? -srcSel : srcSel;

    mulSel = wideIn ? axIn
                    : {{HALF{isSignedIn & axIn[HALF-1]}}, axIn[HALF-1:0]};
    mulNeg = isSignedIn & mulSel[W-1];
    mulMag = mulNeg ? -mulSel : mulSel;

    dividend = wideIn ? {dxIn, axIn} : {{W{isSignedIn & axIn[W-1]}}, axIn};
    dvdNeg   = isSignedIn & dividend[W2-1];
    dvdMag   = dvdNeg ? -dividend : dividend;

    divHi = wideIn ? dvdMag[W2-1:W] : {{HALF{1'b0}}, dvdMag[W-1:HALF]};
    divLo = wideIn ? dvdMag[W-1:0]  : {dvdMag[HALF-1:0], {HALF{1'b0}}};
  end

  // ---------------- working registers ----------------
  logic [W-1:0] hiReg, loReg, mReg, opnd, axSave, dxSave;
  logic         isDivR, isSignedR, wideR, negResR, negRemR, preErrR;

  // ---------------- iteration arithmetic ----------------
  logic [W2-1:0] prodNow, prodNext;
  logic [W:0]    trial;
  logic          trialFits;
  logic [W:0]    trialDiff;

  always_comb begin
    prodNow   = {hiReg, loReg};
    prodNext  = (prodNow << 1) + (mReg[W-1] ? {{W{1'b0}}, opnd} : {W2{1'b0}});
    trial     = {hiReg, loReg[W-1]};
    trialFits = trial >= {1'b0, opnd};
    trialDiff = trial - {1'b0, opnd};
  end

  // ---------------- sign fix-up (finish cycle) ----------------
  logic [W2-1:0] prodVal;
  logic [W-1:0]  quoVal, remVal, limitMag;
  logic          mulWide, rangeErr, divErr;

  always_comb begin
    prodVal = negResR ? -prodNow : prodNow;
    if (wideR) begin
      mulWide = isSignedR ? (prodVal[W2-1:W] != {W{prodVal[W-1]}})
                          : (prodVal[W2-1:W] != '0);
    end else begin
      mulWide = isSignedR ? (prodVal[W-1:HALF] != {HALF{prodVal[HALF-1]}})
                          : (prodVal[W-1:HALF] != '0);
    end

    quoVal   = negResR ? -loReg : loReg;
    remVal   = negRemR ? -hiReg : hiReg;
    limitMag = wideR ? (W'(1) << (W - 1)) : (W'(1) << (HALF - 1));
    rangeErr = isSignedR && (negResR ? (loReg > limitMag)
                                     : (loReg > (limitMag - W'(1))));
    divErr   = preErrR | rangeErr;
  end

  // ---------------- sequential ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg     <= '0;
      loReg     <= '0;
      mReg      <= '0;
      opnd      <= '0;
      axSave    <= '0;
      dxSave    <= '0;
      isDivR    <= 1'b0;
      isSignedR <= 1'b0;
      wideR     <= 1'b0;
      negResR   <= 1'b0;
      negRemR   <= 1'b0;
      preErrR   <= 1'b0;
      axOut     <= '0;
      dxOut     <= '0;
      ovfOut    <= 1'b0;
      carryOut  <= 1'b0;
      divErrOut <= 1'b0;
    end else if (strb.load) begin
      opnd      <= srcMag;
      axSave    <= axIn;
      dxSave    <= dxIn;
      isDivR    <= isDivIn;
      isSignedR <= isSignedIn;
      wideR     <= wideIn;
      if (isDivIn) begin
        hiReg   <= divHi;
        loReg   <= divLo;
        mReg    <= '0;
        negResR <= dvdNeg ^ srcNeg;
        negRemR <= dvdNeg;
        preErrR <= (srcMag == '0) || (divHi >= srcMag);
      end else begin
        hiReg   <= '0;
        loReg   <= '0;
        mReg    <= wideIn ? mulMag : {mulMag[HALF-1:0], {HALF{1'b0}}};
        negResR <= mulNeg ^ srcNeg;
        negRemR <= 1'b0;
        preErrR <= 1'b0;
      end
    end else if (strb.step) begin
      if (isDivR) begin
        hiReg <= trialFits ? trialDiff[W-1:0] : trial[W-1:0];
        loReg <= {loReg[W-2:0], trialFits};
      end else begin
        hiReg <= prodNext[W2-1:W];
        loReg <= prodNext[W-1:0];
        mReg  <= mReg << 1;
      end
    end else if (strb.finish) begin
      if (!isDivR) begin
        axOut     <= prodVal[W-1:0];
        dxOut     <= wideR ? prodVal[W2-1:W] : dxSave;
        ovfOut    <= mulWide;
        carryOut  <= mulWide;
        divErrOut <= 1'b0;
      end else begin
        ovfOut    <= 1'b0;
        carryOut  <= 1'b0;
        divErrOut <= divErr;
        if (divErr) begin
          axOut <= axSave;
          dxOut <= dxSave;
        end else if (wideR) begin
          axOut <= quoVal;
          dxOut <= remVal;
        end else begin
          axOut <= {remVal[HALF-1:0], quoVal[HALF-1:0]};
          dxOut <= dxSave;
        end
      end
    end
  end

endmodule

// File: rtl/muldiv_iter.sv
`timescale 1ns/1ps
module muldiv_iter
  import muldiv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [1:0]        opIn,
  input  logic              wideIn,
  input  logic [DATA_W-1:0] srcIn,
  input  logic [DATA_W-1:0] axIn,
  input  logic [DATA_W-1:0] dxIn,
  output logic [DATA_W-1:0] axOut,
  output logic [DATA_W-1:0] dxOut,
  output logic              ovfOut,
  output logic              carryOut,
  output logic              doneOut,
  output logic              divErrOut
);

  strobe_t strb;

  muldiv_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .wideIn  (wideIn),
    .strb    (strb),
    .doneOut (doneOut)
  );

  muldiv_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opIn      (opIn),
    .wideIn    (wideIn),
    .srcIn     (srcIn),
    .axIn      (axIn),
    .dxIn      (dxIn),
    .axOut     (axOut),
    .dxOut     (dxOut),
    .ovfOut    (ovfOut),
    .carryOut  (carryOut),
    .divErrOut (divErrOut)
  );

endmodule

// File: rtl/muldiv_chk.sv
`timescale 1ns/1ps
module muldiv_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic [1:0]        opIn,
  input logic              wideIn,
  input logic [DATA_W-1:0] axIn,
  input logic [DATA_W-1:0] dxIn,
  input logic [DATA_W-1:0] axOut,
  input logic [DATA_W-1:0] dxOut,
  input logic              ovfOut,
  input logic              carryOut,
  input logic              doneOut,
  input logic              divErrOut
);

  localparam int HALF     = DATA_W / 2;
  localparam int CNTW     = $clog2(DATA_W + 2) + 1;
  localparam int LAT_WORD = DATA_W + 1;
  localparam int LAT_BYTE = HALF + 1;

  // independent shadow of the operation in flight
  logic            ckBusy, ckWide;
  logic [1:0]      ckOp;
  logic [CNTW-1:0] ckCnt, latExp;
  logic [DATA_W-1:0] ckAx, ckDx;

  assign latExp = ckWide ? CNTW'(LAT_WORD) : CNTW'(LAT_BYTE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckBusy <= 1'b0;
      ckWide <= 1'b0;
      ckOp   <= '0;
      ckCnt  <= '0;
      ckAx   <= '0;
      ckDx   <= '0;
    end else if (startIn && !ckBusy) begin
      ckBusy <= 1'b1;
      ckWide <= wideIn;
      ckOp   <= opIn;
      ckCnt  <= '0;
      ckAx   <= axIn;
      ckDx   <= dxIn;
    end else if (ckBusy) begin
      ckCnt <= ckCnt + 1'b1;
      if (ckCnt == latExp - 1'b1) ckBusy <= 1'b0;
    end
  end

  p_flag_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    ovfOut == carryOut);

  p_mulu_byte_ovf_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && ckOp == 2'd0 && !ckWide) |-> (ovfOut == (axOut[DATA_W-1:HALF] != '0)));

  p_muls_word_ovf_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && ckOp == 2'd1 && ckWide) |-> (ovfOut == (dxOut != {DATA_W{axOut[DATA_W-1]}})));

  p_byte_keeps_dx_r1: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !ckWide) |-> (dxOut == ckDx));

  p_err_holds_regs_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && divErrOut) |-> (axOut == ckAx && dxOut == ckDx));

  p_mul_no_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !ckOp[1]) |-> !divErrOut);

  p_div_flags_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && ckOp[1]) |-> (!ovfOut && !carryOut));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  p_done_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (!ckBusy && ckCnt == latExp));

  p_no_done_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    ckBusy |-> !doneOut);

endmodule

bind muldiv_iter muldiv_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startIn   (startIn),
  .opIn      (opIn),
  .wideIn    (wideIn),
  .axIn      (axIn),
  .dxIn      (dxIn),
  .axOut     (axOut),
  .dxOut     (dxOut),
  .ovfOut    (ovfOut),
  .carryOut  (carryOut),
  .doneOut   (doneOut),
  .divErrOut (divErrOut)
);

// File: tb/muldiv_iter_tb.sv
`timescale 1ns/1ps
module muldiv_iter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 28;

  typedef struct packed {
    logic [1:0]  op;
    logic        wide;
    logic [15:0] src;
    logic [15:0] ax;
    logic [15:0] dx;
  } vec_t;

  // stimulus: op, wide, src, ax, dx; expected values come from the model task
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 16'h00FF, 16'h00FF, 16'h5555},
    '{2'd0, 1'b0, 16'h0004, 16'h1203, 16'h5555},
    '{2'd1, 1'b0, 16'h0002, 16'h00FF, 16'h1111},
    '{2'd1, 1'b0, 16'h0080, 16'h0080, 16'h2222},
    '{2'd1, 1'b0, 16'h0008, 16'h0010, 16'h3333},
    '{2'd1, 1'b0, 16'h00FD, 16'h0005, 16'h0000},
    '{2'd0, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000},
    '{2'd0, 1'b1, 16'h0010, 16'h1234, 16'hABCD},
    '{2'd0, 1'b1, 16'h00FF, 16'h0100, 16'h0000},
    '{2'd1, 1'b1, 16'h8000, 16'h8000, 16'h0000},
    '{2'd1, 1'b1, 16'h7FFF, 16'hFFFF, 16'h0000},
    '{2'd1, 1'b1, 16'hFFFB, 16'h0003, 16'h0000},
    '{2'd2, 1'b0, 16'h0007, 16'h0064, 16'h4444},
    '{2'd2, 1'b0, 16'h0001, 16'h00FF, 16'h4444},
    '{2'd2, 1'b0, 16'h0001, 16'h0100, 16'h4444},
    '{2'd2, 1'b0, 16'h0000, 16'h0064, 16'h4444},
    '{2'd3, 1'b0, 16'h0007, 16'hFF9C, 16'h0000},
    '{2'd3, 1'b0, 16'h00F9, 16'h0064, 16'h0000},
    '{2'd3, 1'b0, 16'h0001, 16'hFF80, 16'h0000},
    '{2'd3, 1'b0, 16'h0001, 16'h0080, 16'h0000},
    '{2'd3, 1'b0, 16'h00FF, 16'hFF80, 16'h0000},
    '{2'd2, 1'b1, 16'h0003, 16'h0000, 16'h0001},
    '{2'd2, 1'b1, 16'h0003, 16'h0000, 16'h0003},
    '{2'd3, 1'b1, 16'h0002, 16'hFFF9, 16'hFFFF},
    '{2'd3, 1'b1, 16'hFFFF, 16'h0000, 16'h8000},
    '{2'd3, 1'b1, 16'h0001, 16'h8000, 16'hFFFF},
    '{2'd3, 1'b1, 16'h0000, 16'h1234, 16'h0000},
    '{2'd3, 1'b1, 16'hFFFD, 16'h0007, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        startIn;
  logic [1:0]  opIn;
  logic        wideIn;
  logic [15:0] srcIn, axIn, dxIn;
  logic [15:0] axOut, dxOut;
  logic        ovfOut, carryOut, doneOut, divErrOut;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  muldiv_iter #(.DATA_W(16)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .opIn      (opIn),
    .wideIn    (wideIn),
    .srcIn     (srcIn),
    .axIn      (axIn),
    .dxIn      (dxIn),
    .axOut     (axOut),
    .dxOut     (dxOut),
    .ovfOut    (ovfOut),
    .carryOut  (carryOut),
    .doneOut   (doneOut),
    .divErrOut (divErrOut)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // integer reference model built from the requirements
  task automatic model(input logic [1:0] op, input logic wide,
                       input logic [15:0] src, input logic [15:0] ax, input logic [15:0] dx,
                       output logic [15:0] eAx, output logic [15:0] eDx,
                       output logic eOf, output logic eErr);
    longint a, b, p, q, r;
    eErr = 1'b0;
    eOf  = 1'b0;
    eAx  = ax;
    eDx  = dx;
    if (!op[1]) begin
      if (!wide) begin
        a = op[0] ? longint'($signed(ax[7:0])) : longint'(ax[7:0]);
        b = op[0] ? longint'($signed(src[7:0])) : longint'(src[7:0]);
        p = a * b;
        eAx = p[15:0];
        eOf = op[0] ? (p > 127 || p < -128) : (p > 255);
      end else begin
        a = op[0] ? longint'($signed(ax)) : longint'(ax);
        b = op[0] ? longint'($signed(src)) : longint'(src);
        p = a * b;
        eAx = p[15:0];
        eDx = p[31:16];
        eOf = op[0] ? (p > 32767 || p < -32768) : (p > 65535);
      end
    end else begin
      if (!wide) begin
        a = op[0] ? longint'($signed(ax)) : longint'(ax);
        b = op[0] ? longint'($signed(src[7:0])) : longint'(src[7:0]);
      end else begin
        a = op[0] ? longint'($signed({dx, ax})) : longint'({dx, ax});
        b = op[0] ? longint'($signed(src)) : longint'(src);
      end
      if (b == 0) begin
        eErr = 1'b1;
      end else begin
        q = a / b;
        r = a % b;
        if (!wide) eErr = op[0] ? (q > 127 || q < -128) : (q > 255);
        else       eErr = op[0] ? (q > 32767 || q < -32768) : (q > 65535);
        if (!eErr) begin
          if (!wide) eAx = {r[7:0], q[7:0]};
          else begin
            eAx = q[15:0];
            eDx = r[15:0];
          end
        end
      end
    end
  endtask

  // issue one operation, scramble inputs after capture, wait for done
  task automatic runOp(input logic [1:0] op, input logic wide,
                       input logic [15:0] src, input logic [15:0] ax,
                       input logic [15:0] dx, output int cyc);
    @(negedge clk);
    opIn = op; wideIn = wide; srcIn = src; axIn = ax; dxIn = dx; startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    opIn = ~op; wideIn = ~wide; srcIn = 16'hA5C3; axIn = 16'h3C5A; dxIn = 16'h0FF0;
    cyc = 0;
    while (!doneOut && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] eAx, eDx;
    logic        eOf, eErr;
    int          cyc, pulses;
    string       resTag, flagTag;

    rstN = 1'b0; startIn = 1'b0; opIn = '0; wideIn = 1'b0;
    srcIn = '0; axIn = '0; dxIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11", "reset axOut", 32'(axOut), 32'h0);
    check("R11", "reset dxOut", 32'(dxOut), 32'h0);
    check("R11", "reset flags", {29'b0, ovfOut, carryOut, divErrOut}, 32'h0);
    check("R11", "reset done", 32'(doneOut), 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      model(VECS[i].op, VECS[i].wide, VECS[i].src, VECS[i].ax, VECS[i].dx,
            eAx, eDx, eOf, eErr);
      runOp(VECS[i].op, VECS[i].wide, VECS[i].src, VECS[i].ax, VECS[i].dx, cyc);
      if (!VECS[i].op[1]) begin
        resTag  = VECS[i].wide ? "R2" : "R1";
        flagTag = "R3";
      end else begin
        resTag  = eErr ? "R7" : (VECS[i].op[0] ? "R6" : (VECS[i].wide ? "R5" : "R4"));
        flagTag = "R8";
      end
      check("R9", $sformatf("vec%0d latency", i), 32'(cyc), VECS[i].wide ? 32'd17 : 32'd9);
      check(resTag, $sformatf("vec%0d axOut", i), 32'(axOut), 32'(eAx));
      check(resTag, $sformatf("vec%0d dxOut", i), 32'(dxOut), 32'(eDx));
      check(flagTag, $sformatf("vec%0d ovfOut", i), 32'(ovfOut), 32'(eOf));
      check(flagTag, $sformatf("vec%0d carryOut", i), 32'(carryOut), 32'(eOf));
      check("R7", $sformatf("vec%0d divErrOut", i), 32'(divErrOut), 32'(eErr));
      @(negedge clk);
      check("R9", $sformatf("vec%0d done width", i), 32'(doneOut), 32'h0);
    end

    // R10: second start while busy is ignored
    @(negedge clk);
    opIn = 2'd0; wideIn = 1'b1; srcIn = 16'h0005; axIn = 16'h0003; dxIn = 16'h7777;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (3) @(negedge clk);
    opIn = 2'd3; wideIn = 1'b0; srcIn = 16'h0000; axIn = 16'h9999; dxIn = 16'h8888;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    pulses = 0;
    cyc = 4;
    while (!doneOut && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check("R10", "busy start latency", 32'(cyc), 32'd17);
    check("R10", "busy start axOut", 32'(axOut), 32'h000F);
    check("R10", "busy start dxOut", 32'(dxOut), 32'h0000);
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (doneOut) pulses++;
    end
    check("R10", "extra done pulses", 32'(pulses), 32'd0);

    // R11: reset in mid-operation abandons it
    @(negedge clk);
    opIn = 2'd1; wideIn = 1'b1; srcIn = 16'h0100; axIn = 16'h0100; dxIn = 16'h0000;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    pulses = 0;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (doneOut) pulses++;
    end
    check("R11", "done after mid-op reset", 32'(pulses), 32'd0);
    check("R11", "axOut after mid-op reset", 32'(axOut), 32'h0);
    check("R11", "dxOut after mid-op reset", 32'(dxOut), 32'h0);
    check("R11", "flags after mid-op reset", {30'b0, ovfOut, divErrOut}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule